// File: doc/BRIEF.md
# Vector lane extract-to-scalar unit

This unit decodes and executes one instruction: it copies a single element of a 128-bit vector register value into a scalar result and zero-extends it. The caller gives it a 32-bit instruction word and the current contents of the source vector register. The unit checks the word's fixed opcode bits. It then works out the element size and lane number from one 5-bit field and picks that element out of the vector. One clock later it returns the widened result, the destination register number and a flag that says whether the destination is 32 or 64 bits wide.

The element size comes from the position of the lowest set bit in the 5-bit field. The bits above that position give the lane number. Any reserved combination of size and destination width is reported as an undefined instruction. A word whose fixed opcode bits do not match belongs to some other unit, so this unit drops it without any response.

Top module: `lane_xtract_unit`

## Requirements
- R1: A word is accepted only when `in_valid` is high and its fixed bits match: bit 31 = 0, bits 29..21 = 001110000 and bits 15..10 = 001111. Any other word, or any cycle with `in_valid` low, gives `out_valid` low in the next cycle.
- R2: An accepted word gives `out_valid` high for exactly the next cycle. Accepted words in consecutive cycles give consecutive results.
- R3: With bit 30 (wide) = 0 and field bits 20..16 (sel) ending in 1, the result is the byte lane sel[4:1], taken from vector bits [8i+7:8i].
- R4: With wide = 0 and sel[1:0] = 10, the result is the 16-bit lane sel[4:2].
- R5: With wide = 0 and sel[2:0] = 100, the result is the 32-bit lane sel[4:3].
- R6: With wide = 1 and sel[3:0] = 1000, the result is the 64-bit lane sel[4], and `out_is64` is 1.
- R7: With wide = 0 and sel[2:0] = 000, or with wide = 1 and sel[3:0] ≠ 1000, the word is undefined. In that case `out_valid` and `out_undef` are both 1 and `out_result` is 0. `out_undef` is never high without `out_valid`.
- R8: With wide = 0, `out_is64` is 0 and `out_result[63:32]` is 0.
- R9: `out_rd` equals bits 4..0 of the accepted word. Bits 9..5 (the source register number) have no effect on any output.
- R10: While reset is asserted, `out_valid` and `out_undef` are 0.
- R11: In a cycle where no word was accepted, `out_result`, `out_rd` and `out_is64` keep the values of the last accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction word and vector are presented |
| in_insn | input | 32 | Instruction word |
| in_vec | input | 128 | Source vector register contents |
| out_valid | output | 1 | One-cycle strobe for an accepted word |
| out_undef | output | 1 | Accepted word uses a reserved encoding |
| out_is64 | output | 1 | Destination is 64 bits wide (otherwise 32) |
| out_rd | output | 5 | Destination register number |
| out_result | output | 64 | Zero-extended element |

## Verification
The result of one word is delivered in the same cycle that the next word is captured. The bench provokes this by holding `in_valid` high over long runs that mix legal, undefined and foreign words, so the output registers load or hold on every edge. A behavioural model in the bench predicts the strobe, the undefined flag and the held or new data for every clock. The design's outputs are compared against that prediction each cycle, so a stale value or an output that loads one cycle late shows up as a mismatch.

// File: rtl/lane_xtract_pkg.sv
package lane_xtract_pkg;

  // element size codes, ordered so that width = 8 << code
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  localparam int unsigned IDX_W   = 4;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned REG_W   = 5;

  localparam logic [8:0] OPC_MID = 9'b001110000;
  localparam logic [5:0] OPC_LOW = 6'b001111;

  typedef struct packed {
    logic             hit;
    logic             undef;
    logic             is64;
    esz_e             esz;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] rd;
  } dec_t;

endpackage

// File: rtl/lx_rst_sync.sv
module lx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/lx_field_decode.sv
module lx_field_decode
  import lane_xtract_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);

  logic             wide;
  logic [SEL_W-1:0] sel;
  logic             unused_rn;

  assign wide      = insn[30];
  assign sel       = insn[20:16];
  assign unused_rn = ^insn[9:5];

  always_comb begin
    dec       = '0;
    dec.hit   = !insn[31] && (insn[29:21] == OPC_MID) && (insn[15:10] == OPC_LOW);
    dec.is64  = wide;
    dec.rd    = insn[4:0];
    dec.esz   = ESZ_8;
    dec.idx   = '0;
    dec.undef = 1'b0;
    if (!wide) begin
      casez (sel)
        5'b????1: begin dec.esz = ESZ_8;  dec.idx = sel[4:1];           end
        5'b???10: begin dec.esz = ESZ_16; dec.idx = {1'b0, sel[4:2]};   end
        5'b??100: begin dec.esz = ESZ_32; dec.idx = {2'b00, sel[4:3]};  end
        default:  begin dec.undef = 1'b1;                               end
      endcase
    end else begin
      if (sel[3:0] == 4'b1000) begin
        dec.esz = ESZ_64;
        dec.idx = {3'b000, sel[4]};
      end else begin
        dec.undef = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lx_lane_mux.sv
module lx_lane_mux
  import lane_xtract_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned XLEN  = 64
) (
  input  logic [VEC_W-1:0] vec,
  input  esz_e             esz,
  input  logic [IDX_W-1:0] idx,
  input  logic             is64,
  input  logic             undef,
  output logic [XLEN-1:0]  result
);

  localparam int unsigned NUM_SIZES = $clog2(XLEN / 8) + 1;
  localparam int unsigned HALF      = XLEN / 2;

  logic [XLEN-1:0] cand [NUM_SIZES];

  // one extractor per element width
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int unsigned ES    = 8 << g;
    localparam int unsigned LANES = VEC_W / ES;
    localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 1;
    logic [LW-1:0] lane;
    assign lane    = idx[LW-1:0];
    assign cand[g] = XLEN'(vec[lane*ES +: ES]);
  end

  always_comb begin
    result = cand[esz];
    if (!is64) begin
      result[XLEN-1:HALF] = '0;
    end
    if (undef) begin
      result = '0;
    end
  end

endmodule

// File: rtl/lane_xtract_unit.sv
module lane_xtract_unit
  import lane_xtract_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned XLEN  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_insn,
  input  logic [VEC_W-1:0]  in_vec,
  output logic              out_valid,
  output logic              out_undef,
  output logic              out_is64,
  output logic [REG_W-1:0]  out_rd,
  output logic [XLEN-1:0]   out_result
);

  logic            rst_q_n;
  dec_t            dec;
  logic [XLEN-1:0] lane_res;
  logic            accept;
  logic            valid_d;
  logic            undef_d;

  lx_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  lx_field_decode u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  lx_lane_mux #(.VEC_W(VEC_W), .XLEN(XLEN)) u_mux (
    .vec    (in_vec),
    .esz    (dec.esz),
    .idx    (dec.idx),
    .is64   (dec.is64),
    .undef  (dec.undef),
    .result (lane_res)
  );

  // next state
  always_comb begin
    accept  = in_valid && dec.hit;
    valid_d = accept;
    undef_d = accept && dec.undef;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_undef <= undef_d;
    end
  end

  // data registers, loaded only on accept
  always_ff @(posedge clk) begin
    if (accept) begin
      out_result <= lane_res;
      out_rd     <= dec.rd;
      out_is64   <= dec.is64;
    end
  end

endmodule

// File: rtl/lane_xtract_chk.sv
module lane_xtract_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     in_insn,
  input logic            out_valid,
  input logic            out_undef,
  input logic            out_is64,
  input logic [4:0]      out_rd,
  input logic [XLEN-1:0] out_result
);

  logic acc_c;
  logic seen_q;
  logic unused_bits;

  assign acc_c = in_valid && !in_insn[31] && (in_insn[29:21] == 9'b001110000)
                 && (in_insn[15:10] == 6'b001111);
  assign unused_bits = ^{in_insn[20:16], in_insn[9:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (acc_c) seen_q <= 1'b1;
  end

  assert_foreign_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_c |=> !out_valid);

  assert_accept_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_c |=> out_valid);

  assert_width_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_c |=> out_is64 == $past(in_insn[30]));

  assert_undef_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> (out_valid && out_result == '0));

  assert_narrow_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is64) |-> out_result[XLEN-1:XLEN/2] == '0);

  assert_rd_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_c |=> out_rd == $past(in_insn[4:0]));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !acc_c) |=> ($stable(out_result) && $stable(out_rd) && $stable(out_is64)));

endmodule

bind lane_xtract_unit lane_xtract_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .in_valid   (in_valid),
  .in_insn    (in_insn),
  .out_valid  (out_valid),
  .out_undef  (out_undef),
  .out_is64   (out_is64),
  .out_rd     (out_rd),
  .out_result (out_result)
);

// File: tb/test_lane_xtract_unit.sv
module test_lane_xtract_unit;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  in_insn;
  logic [127:0] in_vec;
  logic         out_valid;
  logic         out_undef;
  logic         out_is64;
  logic [4:0]   out_rd;
  logic [63:0]  out_result;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  bit cmp_en = 0;

  // model state
  bit          exp_valid = 0;
  bit          exp_undef = 0;
  bit          exp_is64  = 0;
  logic [63:0] exp_res   = '0;
  logic [4:0]  exp_rd    = '0;
  int          exp_esz   = 0;
  bit          have_data = 0;

  lane_xtract_unit i_lane_xtract_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_insn    (in_insn),
    .in_vec     (in_vec),
    .out_valid  (out_valid),
    .out_undef  (out_undef),
    .out_is64   (out_is64),
    .out_rd     (out_rd),
    .out_result (out_result)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mk(bit q, logic [4:0] sel, logic [4:0] rn, logic [4:0] rd);
    return {1'b0, q, 9'b001110000, sel, 6'b001111, rn, rd};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic bit ref_hit(logic [31:0] w);
    return (w[31] == 1'b0) && (w[29:21] == 9'h070) && (w[15:10] == 6'h0f);
  endfunction

  task automatic ref_eval(input logic [31:0] w, input logic [127:0] v,
                          output bit u, output logic [63:0] r, output int es);
    int idx;
    logic [4:0] s;
    s = w[20:16]; u = 0; es = 0; idx = 0; r = '0;
    if (!w[30]) begin
      if (s[0])      begin es = 8;  idx = int'(s) >> 1; end
      else if (s[1]) begin es = 16; idx = int'(s) >> 2; end
      else if (s[2]) begin es = 32; idx = int'(s) >> 3; end
      else u = 1;
    end else if (s[3:0] == 4'b1000) begin
      es = 64; idx = int'(s[4]);
    end else u = 1;
    if (!u) for (int b = 0; b < es; b++) r[b] = v[idx*es + b];
  endtask

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reference model, sees only the inputs
  always @(posedge clk) begin
    bit u; logic [63:0] r; int es;
    if (rst_n && in_valid && ref_hit(in_insn)) begin
      ref_eval(in_insn, in_vec, u, r, es);
      exp_valid = 1; exp_undef = u; exp_res = r; exp_rd = in_insn[4:0];
      exp_is64 = in_insn[30]; exp_esz = u ? 0 : es; have_data = 1;
    end else begin
      exp_valid = 0; exp_undef = 0;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    string rt;
    if (cmp_en) begin
      check(out_valid === exp_valid, exp_valid ? "R2" : "R1", "valid",
            64'(out_valid), 64'(exp_valid));
      check(out_undef === exp_undef, "R7", "undef", 64'(out_undef), 64'(exp_undef));
      if (have_data) begin
        if (!exp_valid)           rt = "R11";
        else if (exp_undef)       rt = "R7";
        else if (exp_esz == 8)    rt = "R3";
        else if (exp_esz == 16)   rt = "R4";
        else if (exp_esz == 32)   rt = "R5";
        else                      rt = "R6";
        check(out_result === exp_res, rt, "result", out_result, exp_res);
        check(out_rd === exp_rd, "R9", "rd", 64'(out_rd), 64'(exp_rd));
        check(out_is64 === exp_is64, exp_is64 ? "R6" : "R8", "is64",
              64'(out_is64), 64'(exp_is64));
        if (!exp_is64)
          check(out_result[63:32] === 32'h0, "R8", "upper", 64'(out_result[63:32]), 64'h0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      total++; bad++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", cyc, 50000);
      finish_run();
    end
  end

  task automatic send(logic [31:0] w, logic [127:0] v);
    @(negedge clk);
    in_valid = 1; in_insn = w; in_vec = v;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_insn = $urandom; in_vec = rnd128();
  endtask

  initial begin
    logic [31:0] base;
    logic [127:0] v;
    rst_n = 0; in_valid = 0; in_insn = '0; in_vec = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid === 1'b0, "R10", "valid in reset", 64'(out_valid), 64'h0);
    check(out_undef === 1'b0, "R10", "undef in reset", 64'(out_undef), 64'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_en = 1;

    v = rnd128();
    // R3: every byte lane
    for (int l = 0; l < 16; l++) send(mk(0, {l[3:0], 1'b1}, 5'(l), 5'(l + 3)), v);
    // R4: every halfword lane
    for (int l = 0; l < 8; l++) send(mk(0, {l[2:0], 2'b10}, 5'd7, 5'(l)), rnd128());
    // R5: every word lane
    for (int l = 0; l < 4; l++) send(mk(0, {l[1:0], 3'b100}, 5'd1, 5'(30 - l)), rnd128());
    // R6: both doubleword lanes
    for (int l = 0; l < 2; l++) send(mk(1, {l[0], 4'b1000}, 5'd2, 5'(l + 9)), rnd128());
    idle();
    // R7: reserved narrow encodings
    for (int l = 0; l < 4; l++) send(mk(0, {l[1:0], 3'b000}, 5'd4, 5'(l)), rnd128());
    // R7: reserved wide encodings
    for (int s = 0; s < 32; s++)
      if (s[3:0] != 4'b1000) send(mk(1, 5'(s), 5'd5, 5'(s)), rnd128());
    idle();
    // R1: each fixed bit flipped; R11 the held data must not move
    send(mk(0, 5'b10101, 5'd0, 5'd17), rnd128());
    base = mk(1, 5'b11000, 5'd0, 5'd12);
    for (int b = 0; b < 32; b++)
      if (b == 31 || (b >= 21 && b <= 29) || (b >= 10 && b <= 15))
        send(base ^ (32'h1 << b), rnd128());
    // R1: legal word with in_valid low
    @(negedge clk); in_valid = 0; in_insn = base; in_vec = rnd128();
    idle();
    // R9: source register field has no effect
    v = rnd128();
    for (int rn = 0; rn < 32; rn += 5) send(mk(0, 5'b01100, 5'(rn), 5'd21), v);
    // back-to-back mix, with occasional gaps
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      w = ($urandom % 4 == 0) ? $urandom : mk(1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
      if ($urandom % 7 == 0) idle();
      send(w, rnd128());
    end
    idle();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule